// File: doc/BRIEF.md
# Configurable Serial Audio Input Port

This block receives stereo PCM samples over a three-wire serial link made of a bit clock, a left/right word clock and a data line. It turns the serial stream into parallel 24-bit left and right words and presents each stereo pair together with a one-cycle valid strobe. All format choices are static configuration inputs. They cover justification (left-justified or right-justified), a one-slot delay of the first data bit, the sampling edge of the bit clock, the polarity of the word clock and the word resolution. Setting the delay and inverting the word-clock polarity gives the I2S format.

In slave mode the bit clock, word clock and data come from outside. All three pass through the same multi-stage synchroniser into the system clock domain. The sampling edge is then found by edge detection. In master mode the block divides its system clock to drive the bit clock and word clock itself. The incoming data is still taken through the same synchronised path, so data and clock stay aligned. The bit clock may stop between bits, and the two halves of a frame need not be of equal length.

Top module: `serial_audio_rx`

## Requirements
- R1: With cfg_master_i=1 the block drives sclk_o with a period of 2*CLK_DIV system clocks and toggles lrck_o every HALF_BITS bit periods, always on the non-sampling edge of sclk_o. It samples data on its own clock. With cfg_master_i=0 it holds sclk_o and lrck_o low and uses sclk_i and lrck_i.
- R2: Data and word clock are sampled on the rising bit-clock edge when cfg_sclk_fall_i=0 and on the falling edge when cfg_sclk_fall_i=1.
- R3: With cfg_lr_inv_i=0 a high word clock marks the left channel. With cfg_lr_inv_i=1 a low word clock marks the left channel.
- R4: With cfg_rj_i=1 the last N bits of a half-frame are kept, where N is set by cfg_res_i (00=24, 01=20, 10=16). They are returned MSB-aligned in the 24-bit word with zeros below. Earlier, higher bits are lost.
- R5: With cfg_rj_i=0 the MSB arrives in slot cfg_delay_i (slot 0 is the first sampling edge of the half-frame). Up to 24 bits are taken MSB first. Later bits are ignored, missing bits read as zero, and cfg_res_i has no effect.
- R6: A new channel starts at the first sampling edge at which the word-clock level differs from the level seen at the previous sampling edge. Halves of unequal length and pauses in the bit clock are accepted.
- R7: left_o and right_o update together, with valid_o high for exactly one cycle, when a right half-frame ends that followed a completed left half-frame.
- R8: Reset clears left_o, right_o and valid_o. The partial half-frame in progress when the link is first seen after reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_master_i | input | 1 | 1: generate bit and word clocks; 0: accept them |
| cfg_rj_i | input | 1 | 1: right-justified; 0: left-justified/I2S |
| cfg_delay_i | input | 1 | First data bit one slot after the half-frame start |
| cfg_sclk_fall_i | input | 1 | Sample on the falling bit-clock edge |
| cfg_lr_inv_i | input | 1 | Low word clock marks the left channel |
| cfg_res_i | input | 2 | Resolution: 00=24, 01=20, 10=16 |
| sclk_i | input | 1 | Bit clock in (slave) |
| lrck_i | input | 1 | Word clock in (slave) |
| sdata_i | input | 1 | Serial data, MSB first |
| sclk_o | output | 1 | Bit clock out (master), low in slave |
| lrck_o | output | 1 | Word clock out (master), low in slave |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
A wrong slot counter or a missed word-clock transition shows up on left_o and right_o. The bits come out shifted by one place, the wrong number of low bits are zeroed, or the channels are swapped. This is visible at the very next valid_o, about three system clocks after the first sampling edge of the following frame. A lost left-completed flag shows up a different way: valid_o goes missing, or pulses once per half-frame instead of once per frame. The bench detects this from the number of pairs captured. In master mode, a wrong divider or frame counter changes the measured sclk_o period and the lrck_o toggle interval within one frame.

// File: rtl/sai_pkg.sv
package sai_pkg;
  localparam int SAMPLE_W = 24;
  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef enum logic [1:0] {
    RES_24 = 2'b00,
    RES_20 = 2'b01,
    RES_16 = 2'b10,
    RES_RSV = 2'b11
  } res_e;

  // keep the last N bits of a right-justified word, MSB-aligned
  function automatic sample_t rj_align(sample_t s, logic [1:0] res);
    case (res)
      RES_20:  return {s[19:0], 4'b0};
      RES_16:  return {s[15:0], 8'b0};
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/sai_clkgen.sv
module sai_clkgen #(
  parameter int CLK_DIV   = 4,
  parameter int HALF_BITS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fall_i,
  input  logic lr_inv_i,
  output logic sclk_o,
  output logic lrck_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = (HALF_BITS > 1) ? $clog2(HALF_BITS) : 1;

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic raw_q, ch_q;
  logic tick;

  assign tick = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bit_q <= '0;
      raw_q <= 1'b0;
      ch_q  <= 1'b0;
    end else if (!en_i) begin
      div_q <= '0;
      bit_q <= '0;
      raw_q <= 1'b0;
      ch_q  <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        raw_q <= ~raw_q;
        // word clock moves on the non-sampling edge
        if (raw_q) begin
          if (bit_q == BIT_W'(HALF_BITS - 1)) begin
            bit_q <= '0;
            ch_q  <= ~ch_q;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o = en_i & (raw_q ^ fall_i);
  assign lrck_o = en_i & (ch_q ^ lr_inv_i);

  AST_LR_ON_IDLE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $changed(lrck_o)) |-> (sclk_o == fall_i)); // R1
endmodule

// File: rtl/sai_sync.sv
module sai_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic sdata_i,
  output logic evt_o,
  output logic lr_o,
  output logic dat_o
);
  logic [2:0] pipe_q [STAGES];
  logic edge_lvl, edge_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= '0;
        else         pipe_q[g] <= {sclk_i, lrck_i, sdata_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= '0;
        else         pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign edge_lvl = pipe_q[STAGES-1][2] ^ fall_i;

  // reset high so a falling-edge setup gives no spurious first event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b1;
    else         edge_q <= edge_lvl;
  end

  assign evt_o = edge_lvl & ~edge_q;
  assign lr_o  = pipe_q[STAGES-1][1];
  assign dat_o = pipe_q[STAGES-1][0];

  AST_EVT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o); // R2
endmodule

// File: rtl/sai_deser.sv
module sai_deser
  import sai_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_i,
  input  logic       lr_i,
  input  logic       dat_i,
  input  logic       lr_inv_i,
  input  logic       delay_i,
  input  logic       rj_i,
  input  logic [1:0] res_i,
  output sample_t    left_o,
  output sample_t    right_o,
  output logic       valid_o
);
  localparam int CNT_W = 6;
  localparam int POS_W = $clog2(SAMPLE_W);

  logic primed_q, started_q, prev_left_q, left_ok_q, valid_q;
  logic [CNT_W-1:0] k_q, k_new;
  sample_t acc_q, sr_q, hold_q, left_q, right_q;
  sample_t acc_new, sr_new, word_done, acc_base, sr_base;
  logic [CNT_W:0] d_idx;
  logic is_left, trans, hit;

  always_comb begin
    is_left  = lr_i ^ lr_inv_i;
    trans    = primed_q && (is_left != prev_left_q);
    if (trans)                          k_new = '0;
    else if (k_q == {CNT_W{1'b1}})      k_new = k_q;
    else                                k_new = k_q + 1'b1;
    d_idx    = {1'b0, k_new} - {{CNT_W{1'b0}}, delay_i};
    hit      = !d_idx[CNT_W] && (d_idx < (CNT_W+1)'(SAMPLE_W));
    acc_base = trans ? '0 : acc_q;
    sr_base  = trans ? '0 : sr_q;
    acc_new  = acc_base;
    if (hit) acc_new[POS_W'(SAMPLE_W-1) - d_idx[POS_W-1:0]] = dat_i;
    sr_new    = {sr_base[SAMPLE_W-2:0], dat_i};
    word_done = rj_i ? rj_align(sr_q, res_i) : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q    <= 1'b0;
      started_q   <= 1'b0;
      prev_left_q <= 1'b0;
      left_ok_q   <= 1'b0;
      valid_q     <= 1'b0;
      k_q         <= '0;
      acc_q       <= '0;
      sr_q        <= '0;
      hold_q      <= '0;
      left_q      <= '0;
      right_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (evt_i) begin
        prev_left_q <= is_left;
        if (!primed_q) begin
          primed_q <= 1'b1;
          k_q      <= '0;
        end else begin
          k_q   <= k_new;
          acc_q <= acc_new;
          sr_q  <= sr_new;
          if (trans) begin
            started_q <= 1'b1;
            if (started_q) begin
              if (prev_left_q) begin
                hold_q    <= word_done;
                left_ok_q <= 1'b1;
              end else if (left_ok_q) begin
                left_q    <= hold_q;
                right_q   <= word_done;
                valid_q   <= 1'b1;
                left_ok_q <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R7
  AST_RJ_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && rj_i && res_i == RES_16) |-> (right_q[7:0] == 8'h00)); // R4
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sai_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int HALF_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_master_i,
  input  logic                cfg_rj_i,
  input  logic                cfg_delay_i,
  input  logic                cfg_sclk_fall_i,
  input  logic                cfg_lr_inv_i,
  input  logic [1:0]          cfg_res_i,
  input  logic                sclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  output logic                sclk_o,
  output logic                lrck_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic gen_sclk, gen_lrck;
  logic line_sclk, line_lrck;
  logic evt, lr_s, dat_s;

  sai_clkgen #(.CLK_DIV(CLK_DIV), .HALF_BITS(HALF_BITS)) u_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg_master_i),
    .fall_i   (cfg_sclk_fall_i),
    .lr_inv_i (cfg_lr_inv_i),
    .sclk_o   (gen_sclk),
    .lrck_o   (gen_lrck)
  );

  // generated clocks take the same synchronised path as external ones
  assign line_sclk = cfg_master_i ? gen_sclk : sclk_i;
  assign line_lrck = cfg_master_i ? gen_lrck : lrck_i;

  sai_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (cfg_sclk_fall_i),
    .sclk_i  (line_sclk),
    .lrck_i  (line_lrck),
    .sdata_i (sdata_i),
    .evt_o   (evt),
    .lr_o    (lr_s),
    .dat_o   (dat_s)
  );

  sai_deser u_deser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .lr_i     (lr_s),
    .dat_i    (dat_s),
    .lr_inv_i (cfg_lr_inv_i),
    .delay_i  (cfg_delay_i),
    .rj_i     (cfg_rj_i),
    .res_i    (cfg_res_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  assign sclk_o = gen_sclk;
  assign lrck_o = gen_lrck;

  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_master_i |-> (!sclk_o && !lrck_o)); // R1
endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 4;
  localparam int LIMIT      = 150000;
  localparam int CLK_DIV    = 4;
  localparam int HALF_BITS  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 0, cfg_rj = 0, cfg_dly = 0, cfg_fall = 0, cfg_inv = 0;
  logic [1:0] cfg_res = 2'b00;
  logic sclk_i = 0, lrck_i = 0, sdata_i = 0;
  logic sclk_o, lrck_o, valid_o;
  logic [23:0] left_o, right_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [23:0] cap_l[$];
  logic [23:0] cap_r[$];

  serial_audio_rx #(.CLK_DIV(CLK_DIV), .HALF_BITS(HALF_BITS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_master_i(cfg_master), .cfg_rj_i(cfg_rj), .cfg_delay_i(cfg_dly),
    .cfg_sclk_fall_i(cfg_fall), .cfg_lr_inv_i(cfg_inv), .cfg_res_i(cfg_res),
    .sclk_i(sclk_i), .lrck_i(lrck_i), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .lrck_o(lrck_o),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && valid_o) begin
    cap_l.push_back(left_o);
    cap_r.push_back(right_o);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic idle_lvl();
    return cfg_fall;
  endfunction

  function automatic int res_bits();
    case (cfg_res)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic slot_bit(logic [23:0] w, int k, int n);
    int idx;
    if (cfg_rj) begin
      idx = n - 1 - k;
      return (idx >= 0 && idx < 24) ? w[idx] : 1'b0;
    end
    idx = k - int'(cfg_dly);
    return (idx >= 0 && idx < 24) ? w[23-idx] : 1'b0;
  endfunction

  function automatic logic [23:0] exp_word(logic [23:0] w, int n);
    int r, m;
    logic [23:0] mk;
    if (cfg_rj) begin
      r  = res_bits();
      mk = (r == 24) ? 24'hFFFFFF : ((24'd1 << r) - 24'd1);
      return (w & mk) << (24 - r);
    end
    m = n - int'(cfg_dly);
    if (m >= 24) return w;
    if (m <= 0)  return 24'h0;
    return w & ~((24'd1 << (24 - m)) - 24'd1);
  endfunction

  function automatic logic [23:0] lw(int f);
    return 24'(f * 32'h3C1A57 ^ 32'h5A0F33);
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0;
    sclk_i = idle_lvl(); lrck_i = 1'b0; sdata_i = 1'b0;
    cap_l.delete(); cap_r.delete();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_slot(logic left, logic d, int gap);
    lrck_i  = left ^ cfg_inv;
    sdata_i = d;
    repeat (H + gap) @(negedge clk);
    sclk_i = ~idle_lvl();
    repeat (H) @(negedge clk);
    sclk_i = idle_lvl();
  endtask

  task automatic send_half(logic left, logic [23:0] w, int n, int gap);
    for (int k = 0; k < n; k++) drive_slot(left, slot_bit(w, k, n), gap);
  endtask

  task automatic run_slave(string req, logic [23:0] l0, logic [23:0] r0,
                           logic [23:0] l1, logic [23:0] r1, int nl, int nr, int gap);
    apply_reset();
    drive_slot(1'b0, 1'b1, 0);          // partial right half, discarded (R8)
    send_half(1'b1, l0, nl, gap);
    send_half(1'b0, r0, nr, gap);
    send_half(1'b1, l1, nl, gap);
    send_half(1'b0, r1, nr, gap);
    drive_slot(1'b1, 1'b0, 0);
    repeat (8) @(negedge clk);
    check({req, " R7 pair count"}, 24'(cap_l.size()), 24'd2);
    if (cap_l.size() == 2) begin
      check({req, " left0"},  cap_l[0], exp_word(l0, nl));
      check({req, " right0"}, cap_r[0], exp_word(r0, nr));
      check({req, " left1"},  cap_l[1], exp_word(l1, nl));
      check({req, " right1"}, cap_r[1], exp_word(r1, nr));
    end
  endtask

  task automatic set_cfg(logic m, logic rj, logic dl, logic fl, logic iv, logic [1:0] rs);
    cfg_master = m; cfg_rj = rj; cfg_dly = dl; cfg_fall = fl; cfg_inv = iv; cfg_res = rs;
  endtask

  task automatic t_reset();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset valid", 24'(valid_o), 24'd0);
    check("R8 reset left", left_o, 24'd0);
    check("R8 reset right", right_o, 24'd0);
    apply_reset();
    check("R1 slave sclk_o low", 24'(sclk_o), 24'd0);
    check("R1 slave lrck_o low", 24'(lrck_o), 24'd0);
  endtask

  task automatic t_left_just();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    run_slave("R5 R3 left-justified", 24'hA5C3E1, 24'h5B2D97, 24'h13F0C8, 24'hE86A4F, 24, 24, 0);
  endtask

  task automatic t_res_ignored();
    set_cfg(0, 0, 0, 0, 0, 2'b10);
    run_slave("R5 resolution ignored", 24'hFFFFFF, 24'h00FF01, 24'h8000FF, 24'h7E0181, 24, 24, 0);
  endtask

  task automatic t_i2s();
    set_cfg(0, 0, 1, 0, 1, 2'b00);
    run_slave("R3 R5 i2s delay", 24'hC0FFEE, 24'h123457, 24'h800001, 24'h7FFFFE, 32, 32, 0);
  endtask

  task automatic t_short();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    run_slave("R5 missing clocks", 24'hFFFFFF, 24'hABCDEF, 24'h9F9F9F, 24'hFFFFFF, 16, 20, 0);
  endtask

  task automatic t_rj();
    set_cfg(0, 1, 0, 0, 0, 2'b10);
    run_slave("R4 rj16", 24'hA5C3E1, 24'h5B2D97, 24'h13F0C8, 24'hE86A4F, 24, 24, 0);
    set_cfg(0, 1, 0, 0, 0, 2'b01);
    run_slave("R4 rj20", 24'hFEDCBA, 24'h0F0F0F, 24'h876543, 24'h111111, 32, 32, 0);
    set_cfg(0, 1, 0, 0, 0, 2'b00);
    run_slave("R4 rj24", 24'h9ABCDE, 24'h2468AC, 24'hF00F5A, 24'h0C0C0D, 24, 24, 0);
  endtask

  task automatic t_fall();
    set_cfg(0, 0, 0, 1, 0, 2'b00);
    run_slave("R2 falling edge", 24'h3A5C7E, 24'hC1B2A3, 24'h0000FF, 24'hFF0000, 24, 24, 0);
  endtask

  task automatic t_uneven();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    run_slave("R6 uneven gapped", 24'h6D4B29, 24'hB7E151, 24'h31415F, 24'hCAFE01, 26, 40, 3);
  endtask

  task automatic t_master();
    int k, fr, t, last_rise, per, last_lr, lr_per;
    logic first, prev_s, prev_left, left, prev_line, s;
    set_cfg(1, 0, 1, 0, 1, 2'b00);
    apply_reset();
    k = 0; fr = 0; t = 0; last_rise = -1; per = 0; last_lr = -1; lr_per = 0;
    first = 1'b1; prev_s = sclk_o; prev_left = 1'b0; prev_line = lrck_o;
    while (cap_l.size() < 3 && t < 20000) begin
      s = sclk_o;
      if (s == idle_lvl() && (first || prev_s != idle_lvl())) begin
        left = lrck_o ^ cfg_inv;
        if (first || left != prev_left) begin
          k = 0;
          if (left) fr++;
        end else begin
          k++;
        end
        prev_left = left;
        first = 1'b0;
        sdata_i = slot_bit(left ? lw(fr) : ~lw(fr), k, HALF_BITS);
      end
      if (s && !prev_s) begin
        if (last_rise >= 0) per = t - last_rise;
        last_rise = t;
      end
      if (lrck_o != prev_line) begin
        if (last_lr >= 0) lr_per = t - last_lr;
        last_lr = t;
      end
      prev_s = s; prev_line = lrck_o;
      @(negedge clk);
      t++;
    end
    check("R1 master sclk period", 24'(per), 24'(2 * CLK_DIV));
    check("R1 master lrck interval", 24'(lr_per), 24'(2 * CLK_DIV * HALF_BITS));
    check("R1 master pair count", 24'(cap_l.size()), 24'd3);
    for (int f = 1; f <= 3; f++) begin
      if (cap_l.size() >= f) begin
        check("R1 master left", cap_l[f-1], lw(f));
        check("R1 master right", cap_r[f-1], ~lw(f));
      end
    end
  endtask

  initial begin
    t_reset();
    t_left_just();
    t_res_ignored();
    t_i2s();
    t_short();
    t_rj();
    t_fall();
    t_uneven();
    t_master();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule